// File: doc/BRIEF.md
# Egress Buffer Occupancy and Peak Monitor

This block watches how full an egress buffer is and presents the result to a host through two read-only registers. The byte count coming from the buffer is converted into a coarse level in sixteenths of the buffer. With the default sizing each step is 128 bytes. The level is registered every host cycle and shown live. A watermark register keeps the highest level seen since the host last read it and is cleared by that read.

The live register also carries a flag that tells the host whether the egress clock is running. A flop in the egress domain toggles on every egress clock edge. Its value is synchronized into the host domain, and each change seen there marks the clock as present. If no change is seen for a timeout of host cycles, the flag falls to 0.

The host reads with a strobe and a one-bit register select. Read data is combinational from the select. A peak read takes effect at the clock edge that ends the strobe cycle, so the read returns the peak as it stood before the clear.

Top module: `fill_watch`

## Requirements
- R1: One host clock edge after a byte count is applied, live register bits 3:0 (select 0) read min(floor(count/128), 15).
- R2: Live register bit 4 and bits 7:6 always read 0. Peak register (select 1) bits 7:4 always read 0.
- R3: While the egress clock toggles, live register bit 5 reads 1.
- R4: After the egress clock stops, bit 5 stays 1 for at least 40 host cycles. It reads 0 once 64 host cycles, plus the synchronizer delay, have passed without a detected toggle.
- R5: Peak register bits 3:0 hold the largest level of R1 seen at any clock edge since the last peak read. 15 means the buffer was full.
- R6: A peak read (rd_en=1, rd_sel=1) returns the value held before the read. At that edge the peak restarts from the level of that same cycle if that level exceeds the old peak, and from 0 otherwise.
- R7: After reset, both registers read 0 and the clock flag reads 0 until the egress clock runs.
- R8: Reading the live register (rd_en=1, rd_sel=0) has no effect on the peak register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| egr_clk | input | 1 | Monitored egress clock |
| byte_cnt | input | CNT_W | Buffer occupancy in bytes, host-synchronous |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 = live register, 1 = peak register |
| rd_data | output | 8 | Selected register contents |

## Verification
The bench uses the default parameters: a 12-bit count, a 128-byte unit, a 64-cycle timeout and a two-stage synchronizer. With a 12-bit count, every byte count can be swept upward. Every quantizer boundary is crossed, and so is the saturation region above 2047. A coarser downward sweep with frequent peak reads exercises the watermark clearing, including reads in cycles where the level rises above the old peak. Because the timeout is only 64 cycles, the bench can stop and restart the egress clock to show the flag falling and rising again.

// File: rtl/fill_watch.sv
module fill_watch #(
  parameter int CNT_W     = 12,
  parameter int UNIT_LOG2 = 7,
  parameter int TMO       = 64,
  parameter int SYNC_N    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             egr_clk,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             rd_en,
  input  logic             rd_sel,
  output logic [7:0]       rd_data
);
  localparam int LVL_W   = 4;
  localparam int LVL_MAX = (1 << LVL_W) - 1;
  localparam int TW      = $clog2(TMO + 1);

  logic [CNT_W:0]   quo;
  logic [LVL_W-1:0] lvl, live_q, peak_q;
  logic             tgl_q, edge_seen, clk_ok_q, peak_rd;
  logic [SYNC_N:0]  sy_q;
  logic [TW-1:0]    tmo_q;

  assign quo     = {1'b0, byte_cnt} >> UNIT_LOG2;
  assign lvl     = (quo > (CNT_W+1)'(LVL_MAX)) ? LVL_W'(LVL_MAX) : quo[LVL_W-1:0];
  assign peak_rd = rd_en & rd_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live_q <= '0;
    else        live_q <= lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            peak_q <= '0;
    else if (peak_rd)      peak_q <= (lvl > peak_q) ? lvl : '0;
    else if (lvl > peak_q) peak_q <= lvl;

  always_ff @(posedge egr_clk or negedge rst_n)
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= ~tgl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy_q <= '0;
    else        sy_q <= {sy_q[SYNC_N-1:0], tgl_q};

  assign edge_seen = sy_q[SYNC_N] ^ sy_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmo_q    <= '0;
      clk_ok_q <= 1'b0;
    end else if (edge_seen) begin
      tmo_q    <= '0;
      clk_ok_q <= 1'b1;
    end else if (tmo_q == TW'(TMO - 1)) begin
      clk_ok_q <= 1'b0;
    end else begin
      tmo_q    <= tmo_q + 1'b1;
    end

  assign rd_data = rd_sel ? {4'b0, peak_q} : {2'b0, clk_ok_q, 1'b0, live_q};
endmodule

// File: rtl/fill_watch_chk.sv
module fill_watch_chk #(
  parameter int TMO = 64,
  parameter int TW  = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       rd_sel,
  input logic [7:0] rd_data,
  input logic [3:0] peak,
  input logic [3:0] live,
  input logic       present,
  input logic [TW-1:0] tmo_cnt
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel ? rd_data[7:4] == 4'b0 : (rd_data[4] == 1'b0 && rd_data[7:6] == 2'b0)));

  a_r5_peak_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_sel) |=> peak >= $past(peak));

  a_r5_peak_covers_live: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_sel) |=> peak >= live);

  a_r6_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel) |=> (peak == 4'b0 || peak > $past(peak)));

  a_r4_fall_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(present) |-> $past(tmo_cnt) == TW'(TMO - 1));
endmodule

bind fill_watch fill_watch_chk #(.TMO(TMO), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
  .peak(peak_q), .live(live_q), .present(clk_ok_q), .tmo_cnt(tmo_q));

// File: tb/tb_fill_watch.sv
module tb_fill_watch;
  localparam int CNT_W = 12;

  logic clk = 0, rst_n = 0, egr_clk = 0, egr_run = 0;
  logic [CNT_W-1:0] byte_cnt = '0;
  logic rd_en = 0, rd_sel = 0;
  logic [7:0] rd_data;
  int vec = 0, bad = 0;
  int mp = 0;
  bit flag_e = 0;

  fill_watch dut (.clk(clk), .rst_n(rst_n), .egr_clk(egr_clk), .byte_cnt(byte_cnt),
                  .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data));

  always #2.5 clk = ~clk;
  initial forever begin #7; if (egr_run) egr_clk = ~egr_clk; end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic int lvl_of(int bc);
    return (bc / 128 > 15) ? 15 : bc / 128;
  endfunction

  task automatic step(int bc, bit pk);
    int le;
    byte_cnt = CNT_W'(bc); rd_en = pk; rd_sel = 1'b1;
    #1;
    le = lvl_of(bc);
    if (pk) begin
      chk("R6 peak read", rd_data, 8'(mp));
      mp = (le > mp) ? le : 0;
    end else if (le > mp) mp = le;
    @(negedge clk);
    rd_en = 1'b1; rd_sel = 1'b0;
    #1;
    chk("R1/R2/R3 live", rd_data, {2'b0, flag_e, 1'b0, 4'(le)});
  endtask

  task automatic peek_peak(string req);
    rd_en = 1'b0; rd_sel = 1'b1; #1;
    chk(req, rd_data, 8'(mp));
    rd_sel = 1'b0;
  endtask

  initial begin
    #900000;
    bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    rd_sel = 0; #1; chk("R7 live reset", rd_data, 8'h00);
    rd_sel = 1; #1; chk("R7 peak reset", rd_data, 8'h00);
    rd_sel = 0;
    egr_run = 1;
    repeat (20) @(negedge clk);
    flag_e = 1;
    for (int v = 0; v < (1 << CNT_W); v++) step(v, (v % 37) == 36);
    peek_peak("R5 peak after sweep");
    for (int v = (1 << CNT_W) - 1; v >= 0; v -= 3) step(v, (v % 5) == 0);
    step(100, 1'b1);
    step(100, 1'b1);
    step(1500, 1'b1);
    peek_peak("R6 restart from current level");
    step(1500, 1'b0);
    step(300, 1'b0);
    peek_peak("R8 live reads leave peak");
    step(300, 1'b1);
    step(2047, 1'b0);
    step(2048, 1'b0);
    peek_peak("R5 full level");
    egr_run = 0;
    repeat (40) @(negedge clk);
    step(0, 1'b0);
    repeat (80) @(negedge clk);
    flag_e = 0;
    step(640, 1'b0);
    chk("R4 flag low", {7'b0, rd_data[5]}, 8'h00);
    egr_run = 1;
    repeat (12) @(negedge clk);
    flag_e = 1;
    step(640, 1'b0);
    chk("R3 flag back", {7'b0, rd_data[5]}, 8'h01);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule